// File: doc/BRIEF.md
# Power-of-Two Shift Automatic Gain Control

This block keeps a receive path's level in range by attenuating the incoming sample stream in binary steps. Each input sample is arithmetically shifted right by a shift count N, which divides it by 2^N. The block feeds the shifted stream to the demodulator and watches the demodulator's output on a separate strobed port.

Every monitored sample whose magnitude reaches the high threshold raises N by one, so the attack is fast. A sample that falls between the thresholds leaves N alone. Attenuation is released only after a long quiet run: N drops by one after 10000 consecutive monitored samples below the low threshold. At a 50 kHz sample rate that run lasts 0.2 s.

Both thresholds are inputs, so the control logic can retune them at run time. The current shift count is visible as a status output.

Top module: `shift_agc`

## Requirements
- R1: While rst_ni is low, and after it is released until the first strobe, shift_o is 0, out_valid_o is 0 and out_data_o is 0.
- R2: When in_valid_i is high at a clock edge, out_data_o becomes in_data_i arithmetically shifted right by the current shift_o, rounding toward minus infinity. out_valid_o pulses high for that one cycle.
- R3: out_data_o does not change in any cycle that follows an edge where in_valid_i was low.
- R4: A monitored sample with |mon_data_i| >= thr_hi_i raises shift_o by exactly one, visible in the cycle after the strobe.
- R5: shift_o never exceeds 11. Further overloads at 11 leave it at 11.
- R6: A monitored sample with thr_lo_i <= |mon_data_i| < thr_hi_i leaves shift_o unchanged and restarts the quiet count.
- R7: shift_o drops by one on the 10000th consecutive monitored sample with |mon_data_i| < thr_lo_i, and not before. An overload or mid-range sample restarts the count.
- R8: shift_o never goes below 0. Any number of quiet samples at 0 leave it at 0.
- R9: mon_data_i is ignored in cycles where mon_valid_i is low.
- R10: A monitored value of -2048 counts as magnitude 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 12 | Signed input sample |
| out_valid_o | output | 1 | Shifted sample strobe |
| out_data_o | output | 12 | Signed shifted sample to the demodulator |
| mon_valid_i | input | 1 | Monitored sample strobe |
| mon_data_i | input | 12 | Signed demodulator output being monitored |
| thr_hi_i | input | 12 | Overload magnitude threshold (unsigned) |
| thr_lo_i | input | 12 | Quiet magnitude threshold (unsigned) |
| shift_o | output | 4 | Current shift count N |

## Verification
Both results have one register of latency:
- A strobed input sample shows up on out_data_o and out_valid_o in the cycle after the edge that captured it.
- A monitored strobe updates shift_o in the cycle after its edge.

The bench drives inputs on the falling edge and checks on the next falling edge, half a cycle after the edge that registered the result.

Release timing is checked at the exact boundary. After 9999 quiet strobes shift_o is checked unchanged, and after one more strobe it is checked lower. The same boundary check is repeated after a mid-range sample and after an overload to show that each one restarts the quiet count.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;
endpackage

// File: rtl/agc_level_det.sv
module agc_level_det
  import agc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] mon_data_i,
  input  logic        [DATA_W-1:0] thr_hi_i,
  input  logic        [DATA_W-1:0] thr_lo_i,
  output lvl_e                     lvl_o
);
  logic [DATA_W-1:0] mag;

  // unsigned magnitude; most negative value maps to 2^(DATA_W-1)
  always_comb begin
    if (mon_data_i[DATA_W-1]) mag = ~mon_data_i + 1'b1;
    else                      mag = mon_data_i;
  end

  always_comb begin
    if (mag >= thr_hi_i)     lvl_o = LVL_HIGH;
    else if (mag < thr_lo_i) lvl_o = LVL_LOW;
    else                     lvl_o = LVL_MID;
  end
endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int SHIFT_MAX = 11,
  parameter int HOLD_LEN  = 10000,
  parameter int SHIFT_W   = $clog2(SHIFT_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  lvl_e               lvl_i,
  output logic [SHIFT_W-1:0] shift_o
);
  localparam int HOLD_W = $clog2(HOLD_LEN);

  logic [SHIFT_W-1:0] shift_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               hold_done;

  assign hold_done = (hold_q == HOLD_W'(HOLD_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      hold_q  <= '0;
    end else if (valid_i) begin
      unique case (lvl_i)
        LVL_HIGH: begin
          if (shift_q < SHIFT_W'(SHIFT_MAX)) shift_q <= shift_q + SHIFT_W'(1);
          hold_q <= '0;
        end
        LVL_LOW: begin
          if (hold_done) begin
            if (shift_q != '0) shift_q <= shift_q - SHIFT_W'(1);
            hold_q <= '0;
          end else begin
            hold_q <= hold_q + HOLD_W'(1);
          end
        end
        default: hold_q <= '0;
      endcase
    end
  end

  assign shift_o = shift_q;

  AST_SHIFT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_q <= SHIFT_W'(SHIFT_MAX)); // R5
  AST_HOLD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q < HOLD_W'(HOLD_LEN)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(shift_q)); // R9
  AST_OVERLOAD_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lvl_i == LVL_HIGH && shift_q < SHIFT_W'(SHIFT_MAX))
      |=> shift_q == $past(shift_q) + SHIFT_W'(1)); // R4
  AST_MID_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lvl_i == LVL_MID) |=> ($stable(shift_q) && hold_q == '0)); // R6
  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_q == $past(shift_q)) || (shift_q == $past(shift_q) + SHIFT_W'(1))
      || (shift_q == $past(shift_q) - SHIFT_W'(1))); // R4
endmodule

// File: rtl/agc_shifter.sv
module agc_shifter #(
  parameter int DATA_W  = 12,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  input  logic        [SHIFT_W-1:0] shift_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_data_o
);
  logic signed [DATA_W-1:0] data_q;
  logic                     valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i >>> shift_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o)); // R3
  AST_OUT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (out_data_o[DATA_W-1] == $past(in_data_i[DATA_W-1]))); // R2
endmodule

// File: rtl/shift_agc.sv
module shift_agc
  import agc_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int SHIFT_MAX = 11,
  parameter int HOLD_LEN  = 10000,
  parameter int SHIFT_W   = $clog2(SHIFT_MAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_data_o,
  input  logic                     mon_valid_i,
  input  logic signed [DATA_W-1:0] mon_data_i,
  input  logic        [DATA_W-1:0] thr_hi_i,
  input  logic        [DATA_W-1:0] thr_lo_i,
  output logic        [SHIFT_W-1:0] shift_o
);
  lvl_e               lvl;
  logic [SHIFT_W-1:0] shift;

  agc_level_det #(.DATA_W(DATA_W)) i_det (
    .mon_data_i (mon_data_i),
    .thr_hi_i   (thr_hi_i),
    .thr_lo_i   (thr_lo_i),
    .lvl_o      (lvl)
  );

  agc_ctrl #(.SHIFT_MAX(SHIFT_MAX), .HOLD_LEN(HOLD_LEN), .SHIFT_W(SHIFT_W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (mon_valid_i),
    .lvl_i   (lvl),
    .shift_o (shift)
  );

  agc_shifter #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .shift_i     (shift),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  assign shift_o = shift;

  AST_OUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R2
endmodule

// File: tb/test_shift_agc.sv
`timescale 1ns/1ps
module test_shift_agc;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [11:0] in_data = '0;
  logic              out_valid;
  logic signed [11:0] out_data;
  logic              mon_valid = 1'b0;
  logic signed [11:0] mon_data = '0;
  logic [11:0]       thr_hi = 12'd1500;
  logic [11:0]       thr_lo = 12'd200;
  logic [3:0]        shift;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  shift_agc i_shift_agc (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .mon_valid_i(mon_valid), .mon_data_i(mon_data),
    .thr_hi_i(thr_hi), .thr_lo_i(thr_lo), .shift_o(shift)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive n back-to-back monitor strobes, then check on next negedge
  task automatic mon_run(input int val, input int n);
    @(negedge clk);
    mon_valid = 1'b1;
    mon_data  = 12'(val);
    repeat (n) @(posedge clk);
    @(negedge clk);
    mon_valid = 1'b0;
  endtask

  task automatic send(input int val, input int exp, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 12'(val);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " out_data"}, int'(out_data), exp);
  endtask

  task automatic t_reset;
    chk("R1 shift", int'(shift), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_data", int'(out_data), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 shift after release", int'(shift), 0);
  endtask

  task automatic t_path;
    send(1000, 1000, "R2 n0 pos");
    send(-1, -1, "R2 n0 neg");
  endtask

  task automatic t_attack;
    mon_run(1600, 1);
    chk("R4 first overload", int'(shift), 1);
    send(-1000, -500, "R2 n1");
    mon_run(-2048, 1);
    chk("R10 most negative", int'(shift), 2);
    send(-7, -2, "R2 n2 floor");
  endtask

  task automatic t_hold_out;
    send(400, 100, "R2 n2 pos");
    @(negedge clk); in_data = 12'(-900);
    repeat (4) @(negedge clk);
    chk("R3 hold data", int'(out_data), 100);
    chk("R3 valid low", int'(out_valid), 0);
  endtask

  task automatic t_idle;
    @(negedge clk); mon_data = 12'(2047);
    repeat (5) @(negedge clk);
    chk("R9 ignored", int'(shift), 2);
  endtask

  task automatic t_saturate;
    mon_run(1500, 12);
    chk("R5 clamp", int'(shift), 11);
    send(-2048, -1, "R2 n11 neg");
    send(2047, 0, "R2 n11 pos");
  endtask

  task automatic t_mid;
    mon_run(800, 3);
    chk("R6 mid keep", int'(shift), 11);
  endtask

  task automatic t_release;
    mon_run(100, 9999);
    chk("R7 before boundary", int'(shift), 11);
    mon_run(-100, 1);
    chk("R7 at boundary", int'(shift), 10);
    mon_run(100, 5000);
    mon_run(1499, 1);
    mon_run(100, 9999);
    chk("R6 mid restarts count", int'(shift), 10);
    mon_run(100, 1);
    chk("R7 after mid", int'(shift), 9);
    mon_run(100, 5000);
    mon_run(1600, 1);
    chk("R4 overload mid release", int'(shift), 10);
    mon_run(100, 9999);
    chk("R7 overload restarts count", int'(shift), 10);
    mon_run(100, 1);
    chk("R7 after overload", int'(shift), 9);
  endtask

  task automatic t_floor;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", int'(shift), 0);
    rst_n = 1'b1;
    mon_run(0, 20001);
    chk("R8 floor", int'(shift), 0);
    send(-300, -300, "R8 gain unity");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_path();
    t_attack();
    t_hold_out();
    t_idle();
    t_saturate();
    t_mid();
    t_release();
    t_floor();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule